// File: doc/BRIEF.md
# Scalar AES Round-Step Unit

This execute-stage unit performs one byte's worth of an AES round for a 32-bit core. Each operation takes an accumulator word, a state word and a lane index. It pulls one byte out of the state word and substitutes it through the forward or inverse AES S-box. For middle rounds it also expands the substituted byte into that byte's column share of the forward or inverse MixColumns. It then turns the resulting word so that the share lands in the selected row, and folds it into the accumulator with XOR.

Software builds a complete round from sixteen such operations. It starts each output column from a round-key word and chains four operations into it. The row shift of AES is not done here. It comes from which state word and lane index the caller supplies for each step. Key expansion and the order of operations belong to the caller.

Top module: `aes_round_step`

## Requirements
- R1: While `rst_n` is low, and after reset until the first clock edge with `rst_n` high, `result` is zero (registered variant, the default).
- R2: The substituted byte is `src_b[8*lane_sel+7 : 8*lane_sel]`. The other three bytes of `src_b` have no effect on `result`.
- R3: With `op_dec`=0 and `op_mid`=0 (encrypt, final round), the column share is the forward S-box output s, zero-extended to 32 bits.
- R4: With `op_dec`=0 and `op_mid`=1 (encrypt, middle round), the column share is {3·s, s, s, 2·s}, listed from the top byte down to the bottom byte.
- R5: With `op_dec`=1 and `op_mid`=0 (decrypt, final round), the column share is the inverse S-box output s, zero-extended to 32 bits.
- R6: With `op_dec`=1 and `op_mid`=1 (decrypt, middle round), the column share is {0x0B·s, 0x0D·s, 0x09·s, 0x0E·s}, listed from the top byte down to the bottom byte.
- R7: `result` = `src_a` XOR (column share rotated left by 8*`lane_sel` bits).
- R8: `result` reflects the inputs present at a rising clock edge. It changes only at that edge and holds the previous value until then.
- R9: All products are in GF(2^8) with the reduction polynomial 0x11B. The forward S-box is the multiplicative inverse followed by the standard affine map, so 0x00 maps to 0x63 and 0x53 maps to 0xED. The inverse S-box undoes it, so 0x00 maps to 0x52.
- R10: Chains of operations, started from the expanded round keys, reproduce the published AES-128 example block in both directions. With key 000102…0f, plaintext 00112233…eeff encrypts to 69c4e0d8…c55a. Decryption uses round keys passed through InvMixColumns for the middle rounds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_a | input | 32 | Accumulator word that the column share is XORed into |
| src_b | input | 32 | State word that supplies the substituted byte |
| lane_sel | input | 2 | Byte lane index: selects the source byte and sets the output rotation |
| op_dec | input | 1 | 1 = decrypt (inverse S-box and inverse mix), 0 = encrypt |
| op_mid | input | 1 | 1 = middle round (mix applied), 0 = final round |
| result | output | 32 | Accumulated word |

## Verification
The bench builds the unit with its default parameters: a registered output and four 8-bit lanes. This brings the reset value and the one-edge latency within reach, along with every combination of the four lane indices and the four operation kinds. A byte-level reference model, derived independently from field arithmetic, is compared against the unit on random operands and on directed S-box corner values. The full AES-128 example block is then run through the unit in both directions, so the ordering of lanes and rotations is tested as software would use it. The combinational variant (`OUT_REG`=0) is not built by the bench.

// File: rtl/aes_step_pkg.sv
package aes_step_pkg;

  localparam int unsigned BYTE_W        = 8;
  localparam int unsigned COLUMN_LANES  = 4;
  localparam int unsigned STEP_WORD_W   = BYTE_W * COLUMN_LANES;
  localparam logic [7:0]  GF_REDUCE     = 8'h1B;  // low byte of 0x11B
  localparam logic [7:0]  AFFINE_FWD_C  = 8'h63;
  localparam logic [7:0]  AFFINE_INV_C  = 8'h05;
  localparam logic [7:0]  INV_EXPONENT  = 8'hFE;  // a^254 == a^-1

  typedef logic [BYTE_W-1:0] gf_byte_t;

  function automatic gf_byte_t gf_xtime(input gf_byte_t a);
    return {a[6:0], 1'b0} ^ (a[7] ? GF_REDUCE : 8'h00);
  endfunction

  function automatic gf_byte_t gf_mul(input gf_byte_t a, input gf_byte_t b);
    gf_byte_t acc;
    gf_byte_t pw;
    acc = '0;
    pw  = a;
    for (int i = 0; i < BYTE_W; i++) begin
      if (b[i]) acc = acc ^ pw;
      pw = gf_xtime(pw);
    end
    return acc;
  endfunction

  function automatic gf_byte_t gf_inv(input gf_byte_t a);
    gf_byte_t acc;
    gf_byte_t pw;
    acc = 8'h01;
    pw  = a;
    for (int i = 0; i < BYTE_W; i++) begin
      if (INV_EXPONENT[i]) acc = gf_mul(acc, pw);
      pw = gf_mul(pw, pw);
    end
    return acc;
  endfunction

  function automatic gf_byte_t rotl_byte(input gf_byte_t a, input int unsigned n);
    logic [2*BYTE_W-1:0] dbl;
    dbl = {a, a} << n;
    return dbl[2*BYTE_W-1:BYTE_W];
  endfunction

  function automatic gf_byte_t affine_fwd(input gf_byte_t x);
    return x ^ rotl_byte(x, 1) ^ rotl_byte(x, 2) ^ rotl_byte(x, 3)
             ^ rotl_byte(x, 4) ^ AFFINE_FWD_C;
  endfunction

  function automatic gf_byte_t affine_inv(input gf_byte_t x);
    return rotl_byte(x, 1) ^ rotl_byte(x, 3) ^ rotl_byte(x, 6) ^ AFFINE_INV_C;
  endfunction

endpackage

// File: rtl/aes_byte_pick.sv
module aes_byte_pick #(
  parameter int unsigned WORD_W = 32,
  parameter int unsigned LANE_W = 8
) (
  input  logic [WORD_W-1:0]                  word_in,
  input  logic [$clog2(WORD_W/LANE_W)-1:0]   sel,
  output logic [LANE_W-1:0]                  lane_out
);

  localparam int unsigned LANES = WORD_W / LANE_W;

  logic [LANE_W-1:0] lanes [LANES];

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign lanes[k] = word_in[k*LANE_W +: LANE_W];
  end

  assign lane_out = lanes[sel];

endmodule

// File: rtl/aes_sbox_shared.sv
module aes_sbox_shared
  import aes_step_pkg::*;
(
  input  logic [BYTE_W-1:0] din,
  input  logic              inverse,
  output logic [BYTE_W-1:0] dout
);

  // Single field inverter shared by both directions:
  // forward = affine(inv(x)), inverse = inv(affine^-1(x)).
  logic [BYTE_W-1:0] pre_map;
  logic [BYTE_W-1:0] field_inv;

  always_comb begin
    pre_map   = inverse ? affine_inv(din) : din;
    field_inv = gf_inv(pre_map);
    dout      = inverse ? field_inv : affine_fwd(field_inv);
  end

endmodule

// File: rtl/aes_mix_contrib.sv
module aes_mix_contrib
  import aes_step_pkg::*;
(
  input  logic [BYTE_W-1:0]      sbyte,
  input  logic                   inverse,
  input  logic                   mix_en,
  output logic [STEP_WORD_W-1:0] contrib
);

  // Every multiple comes from one doubling chain: s, 2s, 4s, 8s.
  logic [BYTE_W-1:0] m2, m4, m8;
  logic [BYTE_W-1:0] m3, m9, m11, m13, m14;

  always_comb begin
    m2  = gf_xtime(sbyte);
    m4  = gf_xtime(m2);
    m8  = gf_xtime(m4);
    m3  = m2 ^ sbyte;
    m9  = m8 ^ sbyte;
    m11 = m8 ^ m2 ^ sbyte;
    m13 = m8 ^ m4 ^ sbyte;
    m14 = m8 ^ m4 ^ m2;
    if (!mix_en) begin
      contrib = {{(STEP_WORD_W-BYTE_W){1'b0}}, sbyte};
    end else if (inverse) begin
      contrib = {m11, m13, m9, m14};
    end else begin
      contrib = {m3, sbyte, sbyte, m2};
    end
  end

endmodule

// File: rtl/aes_lane_rotate.sv
module aes_lane_rotate #(
  parameter int unsigned WORD_W = 32,
  parameter int unsigned LANE_W = 8
) (
  input  logic [WORD_W-1:0]                  word_in,
  input  logic [$clog2(WORD_W/LANE_W)-1:0]   sel,
  output logic [WORD_W-1:0]                  word_out
);

  localparam int unsigned LANES = WORD_W / LANE_W;

  logic [WORD_W-1:0] rot [LANES];

  for (genvar k = 0; k < LANES; k++) begin : g_rot
    if (k == 0) begin : g_ident
      assign rot[k] = word_in;
    end else begin : g_shift
      assign rot[k] = {word_in[WORD_W-1-k*LANE_W:0], word_in[WORD_W-1:WORD_W-k*LANE_W]};
    end
  end

  assign word_out = rot[sel];

endmodule

// File: rtl/aes_round_step.sv
module aes_round_step
  import aes_step_pkg::*;
#(
  parameter bit OUT_REG = 1'b1
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic [STEP_WORD_W-1:0]                 src_a,
  input  logic [STEP_WORD_W-1:0]                 src_b,
  input  logic [$clog2(COLUMN_LANES)-1:0]        lane_sel,
  input  logic                                   op_dec,
  input  logic                                   op_mid,
  output logic [STEP_WORD_W-1:0]                 result
);

  localparam int unsigned WORD_W = STEP_WORD_W;

  // Named internal events, brought out for the checker.
  logic                mix_en;
  logic [BYTE_W-1:0]   picked_byte;
  logic [BYTE_W-1:0]   sbox_byte;
  logic [WORD_W-1:0]   contrib_w;
  logic [WORD_W-1:0]   placed_w;
  logic [WORD_W-1:0]   step_w;

  assign mix_en = op_mid;

  aes_byte_pick #(
    .WORD_W (WORD_W),
    .LANE_W (BYTE_W)
  ) u_pick (
    .word_in  (src_b),
    .sel      (lane_sel),
    .lane_out (picked_byte)
  );

  aes_sbox_shared u_sbox (
    .din     (picked_byte),
    .inverse (op_dec),
    .dout    (sbox_byte)
  );

  aes_mix_contrib u_mix (
    .sbyte   (sbox_byte),
    .inverse (op_dec),
    .mix_en  (mix_en),
    .contrib (contrib_w)
  );

  aes_lane_rotate #(
    .WORD_W (WORD_W),
    .LANE_W (BYTE_W)
  ) u_rot (
    .word_in  (contrib_w),
    .sel      (lane_sel),
    .word_out (placed_w)
  );

  assign step_w = src_a ^ placed_w;

  if (OUT_REG) begin : g_reg
    logic [WORD_W-1:0] result_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) result_q <= '0;
      else        result_q <= step_w;
    end
    assign result = result_q;
  end else begin : g_comb
    assign result = step_w;
  end

endmodule

// File: rtl/aes_round_step_chk.sv
module aes_round_step_chk
  import aes_step_pkg::*;
#(
  parameter bit OUT_REG = 1'b1
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   op_dec,
  input logic                   mix_en,
  input logic [BYTE_W-1:0]      picked_byte,
  input logic [BYTE_W-1:0]      sbox_byte,
  input logic [STEP_WORD_W-1:0] contrib,
  input logic [STEP_WORD_W-1:0] src_a,
  input logic [STEP_WORD_W-1:0] result
);

  // R1
  always @(negedge clk) begin
    if (OUT_REG && !rst_n) begin
      reset_zero_chk: assert (result == '0);
    end
  end

  // R3
  final_share_narrow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mix_en |-> (contrib[STEP_WORD_W-1:BYTE_W] == '0 && contrib[BYTE_W-1:0] == sbox_byte));

  // R4
  fwd_share_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mix_en && !op_dec) |-> (contrib[23:16] == contrib[15:8]
                             && contrib[7:0] == gf_xtime(contrib[15:8])
                             && contrib[31:24] == (contrib[7:0] ^ contrib[15:8])));

  // R6
  inv_share_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mix_en && op_dec) |-> ((contrib[23:16] ^ contrib[15:8])
                            == gf_xtime(contrib[31:24] ^ contrib[15:8])));

  // R9
  fwd_sbox_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!op_dec && picked_byte == 8'h00) |-> sbox_byte == 8'h63);

  // R9
  inv_sbox_corner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_dec && picked_byte == 8'h63) |-> sbox_byte == 8'h00);

  if (OUT_REG) begin : g_reg_chk
    // R7
    rotate_weight_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> ($countones(result ^ $past(src_a)) == $countones($past(contrib))));
  end else begin : g_comb_chk
    // R7
    rotate_weight_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |-> ($countones(result ^ src_a) == $countones(contrib)));
  end

endmodule

bind aes_round_step aes_round_step_chk #(.OUT_REG(OUT_REG)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .op_dec      (op_dec),
  .mix_en      (mix_en),
  .picked_byte (picked_byte),
  .sbox_byte   (sbox_byte),
  .contrib     (contrib_w),
  .src_a       (src_a),
  .result      (result)
);

// File: tb/aes_round_step_bench.sv
module aes_round_step_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] src_a = '0;
  logic [31:0] src_b = '0;
  logic [1:0]  lane_sel = '0;
  logic        op_dec = 1'b0;
  logic        op_mid = 1'b0;
  logic [31:0] result;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  logic [7:0]  fs  [256];
  logic [7:0]  isb [256];
  logic [31:0] rk  [44];

  always #10 clk = ~clk;  // 50 MHz

  aes_round_step u_aes_round_step (
    .clk      (clk),
    .rst_n    (rst_n),
    .src_a    (src_a),
    .src_b    (src_b),
    .lane_sel (lane_sel),
    .op_dec   (op_dec),
    .op_mid   (op_mid),
    .result   (result)
  );

  // ---------------- reference arithmetic ----------------
  function automatic logic [7:0] b_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] acc = 8'h00;
    for (int i = 7; i >= 0; i--) begin
      acc = {acc[6:0], 1'b0} ^ (acc[7] ? 8'h1B : 8'h00);
      if (b[i]) acc = acc ^ a;
    end
    return acc;
  endfunction

  function automatic logic [7:0] b_recip(input logic [7:0] a);
    if (a == 8'h00) return 8'h00;
    for (int y = 1; y < 256; y++)
      if (b_mul(a, y[7:0]) == 8'h01) return y[7:0];
    return 8'h00;
  endfunction

  function automatic logic [7:0] b_affine(input logic [7:0] x);
    logic [7:0] r;
    logic [7:0] c = 8'h63;
    for (int i = 0; i < 8; i++)
      r[i] = x[i] ^ x[(i+4)%8] ^ x[(i+5)%8] ^ x[(i+6)%8] ^ x[(i+7)%8] ^ c[i];
    return r;
  endfunction

  function automatic logic [31:0] ref_step(input logic [31:0] a, input logic [31:0] b,
                                           input int bs, input bit dec, input bit mid);
    logic [7:0]  x, s;
    logic [7:0]  c [4];
    logic [31:0] r;
    x = b[8*bs +: 8];
    s = dec ? isb[x] : fs[x];
    if (!mid) begin
      c[0] = s; c[1] = 8'h00; c[2] = 8'h00; c[3] = 8'h00;
    end else if (!dec) begin
      c[0] = b_mul(s, 8'h02); c[1] = s; c[2] = s; c[3] = b_mul(s, 8'h03);
    end else begin
      c[0] = b_mul(s, 8'h0E); c[1] = b_mul(s, 8'h09);
      c[2] = b_mul(s, 8'h0D); c[3] = b_mul(s, 8'h0B);
    end
    r = a;
    for (int i = 0; i < 4; i++) r[8*((i+bs)%4) +: 8] = r[8*((i+bs)%4) +: 8] ^ c[i];
    return r;
  endfunction

  function automatic logic [31:0] inv_mix_col(input logic [31:0] w);
    logic [7:0]  c [4];
    logic [31:0] r;
    for (int i = 0; i < 4; i++) c[i] = w[8*i +: 8];
    for (int i = 0; i < 4; i++)
      r[8*i +: 8] = b_mul(c[i], 8'h0E) ^ b_mul(c[(i+1)%4], 8'h0B)
                  ^ b_mul(c[(i+2)%4], 8'h0D) ^ b_mul(c[(i+3)%4], 8'h09);
    return r;
  endfunction

  // ---------------- bench helpers ----------------
  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: got %08h expected %08h", req, got, exp);
    end
  endtask

  task automatic run_op(input logic [31:0] a, input logic [31:0] b, input int bs,
                        input bit dec, input bit mid, output logic [31:0] got);
    @(negedge clk);
    src_a = a; src_b = b; lane_sel = bs[1:0]; op_dec = dec; op_mid = mid;
    @(negedge clk);
    got = result;
  endtask

  function automatic string req_of(input bit dec, input bit mid);
    if (!dec && mid)  return "R4 enc-mid";
    if (!dec && !mid) return "R3 enc-final";
    if (dec && !mid)  return "R5 dec-final";
    return "R6 dec-mid";
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (60000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  // ---------------- stimulus ----------------
  initial begin : main
    logic [31:0] got, got2, exp, tmp, rc;
    logic [31:0] t [4];
    logic [31:0] u [4];
    logic [31:0] pt [4];
    logic [31:0] ct [4];
    void'($urandom(32'd20240611));

    for (int v = 0; v < 256; v++) fs[v] = b_affine(b_recip(v[7:0]));
    for (int v = 0; v < 256; v++) isb[fs[v]] = v[7:0];

    // R1: reset holds result at zero even with live inputs
    src_a = 32'hDEADBEEF; src_b = 32'h01234567; op_mid = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 during reset", result, 32'h0);
    rst_n = 1'b1;
    #5;
    check("R1 after release before edge", result, 32'h0);

    // R9: S-box corner values, lane 0, zero accumulator
    run_op(32'h0, 32'h00000000, 0, 1'b0, 1'b0, got);
    check("R9 fwd sbox 00", got, 32'h00000063);
    run_op(32'h0, 32'h00000053, 0, 1'b0, 1'b0, got);
    check("R9 fwd sbox 53", got, 32'h000000ED);
    run_op(32'h0, 32'h00000000, 0, 1'b1, 1'b0, got);
    check("R9 inv sbox 00", got, 32'h00000052);

    // R7: share placed by lane index and XORed into the accumulator
    for (int bs = 0; bs < 4; bs++) begin
      run_op(32'hA5A5A5A5, 32'h0, bs, 1'b0, 1'b0, got);
      check("R7 lane placement", got, 32'hA5A5A5A5 ^ (32'h63 << (8*bs)));
    end

    // R4 / R6 directed: source byte 0x00 in lane 1
    run_op(32'h0, 32'h0, 1, 1'b0, 1'b1, got);
    check("R4 enc-mid byte 00 lane1", got, ref_step(32'h0, 32'h0, 1, 1'b0, 1'b1));
    run_op(32'h0, 32'h0, 3, 1'b1, 1'b1, got);
    check("R6 dec-mid byte 00 lane3", got, ref_step(32'h0, 32'h0, 3, 1'b1, 1'b1));

    // R2: unselected bytes of src_b have no effect
    for (int bs = 0; bs < 4; bs++) begin
      tmp = 32'h11223344;
      run_op(32'h0F0F0F0F, tmp, bs, 1'b0, 1'b1, got);
      run_op(32'h0F0F0F0F, (tmp & (32'hFF << (8*bs))) | (~tmp & ~(32'hFF << (8*bs))),
             bs, 1'b0, 1'b1, got2);
      check("R2 unselected bytes ignored", got2, got);
      check("R2 selected byte value", got, ref_step(32'h0F0F0F0F, tmp, bs, 1'b0, 1'b1));
    end

    // R8: result holds until the edge, then takes the new value
    run_op(32'h12345678, 32'h9ABCDEF0, 2, 1'b1, 1'b1, got);
    @(negedge clk);
    src_a = 32'h0; src_b = 32'h000000FF; lane_sel = 2'd0; op_dec = 1'b0; op_mid = 1'b0;
    #5;
    check("R8 holds before edge", result, got);
    @(negedge clk);
    check("R8 updates after edge", result, ref_step(32'h0, 32'h000000FF, 0, 1'b0, 1'b0));

    // Random operands over all operation kinds and lanes (R3..R7)
    for (int it = 0; it < 400; it++) begin
      logic [31:0] a, b;
      int bs;
      bit dec, mid;
      a = $urandom; b = $urandom; bs = $urandom % 4;
      dec = $urandom % 2; mid = $urandom % 2;
      run_op(a, b, bs, dec, mid, got);
      exp = ref_step(a, b, bs, dec, mid);
      check(req_of(dec, mid), got, exp);
    end

    // R10: AES-128 key expansion (bench side), words little-endian per column
    rk[0] = 32'h03020100; rk[1] = 32'h07060504; rk[2] = 32'h0B0A0908; rk[3] = 32'h0F0E0D0C;
    rc = 32'h01;
    for (int i = 4; i < 44; i++) begin
      tmp = rk[i-1];
      if (i % 4 == 0) begin
        tmp = {tmp[7:0], tmp[31:8]};
        tmp = {fs[tmp[31:24]], fs[tmp[23:16]], fs[tmp[15:8]], fs[tmp[7:0]]} ^ rc;
        rc  = {24'h0, b_mul(rc[7:0], 8'h02)};
      end
      rk[i] = rk[i-4] ^ tmp;
    end
    pt[0] = 32'h33221100; pt[1] = 32'h77665544; pt[2] = 32'hBBAA9988; pt[3] = 32'hFFEEDDCC;
    ct[0] = 32'hD8E0C469; ct[1] = 32'h30047B6A; ct[2] = 32'h80B7CDD8; ct[3] = 32'h5AC5B470;

    // R10 encrypt through the unit
    for (int j = 0; j < 4; j++) t[j] = pt[j] ^ rk[j];
    for (int r = 1; r <= 10; r++) begin
      for (int j = 0; j < 4; j++) begin
        u[j] = rk[4*r + j];
        for (int k = 0; k < 4; k++)
          run_op(u[j], t[(j+k)%4], k, 1'b0, (r != 10), u[j]);
      end
      for (int j = 0; j < 4; j++) t[j] = u[j];
    end
    for (int j = 0; j < 4; j++) check("R10 AES-128 encrypt block", t[j], ct[j]);

    // R10 decrypt through the unit
    for (int j = 0; j < 4; j++) t[j] = ct[j] ^ rk[40 + j];
    for (int r = 9; r >= 0; r--) begin
      for (int j = 0; j < 4; j++) begin
        u[j] = (r != 0) ? inv_mix_col(rk[4*r + j]) : rk[j];
        for (int k = 0; k < 4; k++)
          run_op(u[j], t[(j+4-k)%4], k, 1'b1, (r != 0), u[j]);
      end
      for (int j = 0; j < 4; j++) t[j] = u[j];
    end
    for (int j = 0; j < 4; j++) check("R10 AES-128 decrypt block", t[j], pt[j]);

    finish_run();
  end

endmodule